// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Check

This block holds the in-flight loads of an out-of-order core in a circular buffer. Loads enter in program order, each tagged with a sequence number and with the store-queue position that was current when it entered. When a load executes, its effective address is written into its slot. Commit retires loads from the oldest end once the committed sequence number has reached them. A misprediction squash trims the youngest loads from the newest end.

When a store executes, it asks the queue to walk the loads younger than itself. The walk starts at the load index the store captured when it was allocated. A load that already holds an address in the same coarse region as the store has run too early. The first such load is held as the violator until the pipeline reads it. The walk covers one slot per clock, so the requester sees a busy flag and then a one-cycle done pulse with a fault bit.

Top module: `lq_order_queue`

## Requirements
- R1: After reset the queue is empty. `free_count` equals DEPTH, `full`, `viol_valid`, `chk_busy` and `chk_done` are 0, and `alloc_idx` is 0.
- R2: An accepted allocation writes the load into slot `alloc_idx` and reduces `free_count` by one. `alloc_idx` then advances by one and wraps from DEPTH (the last of DEPTH+1 physical slots) back to 0.
- R3: With DEPTH loads held, `full` is 1 and `free_count` is 0. A further allocation is ignored: `alloc_idx` and `free_count` do not change.
- R4: Each load records a store tag of SQ_IDX_W+1 bits. The tag is {1'b1, zeros} when `sq_empty` is 1, and {1'b0, `sq_tail`} otherwise. It is reported on `viol_sqtag` when that load becomes the violator.
- R5: In each cycle with `commit_valid` and no squash, the oldest load is retired if the queue is not empty and its sequence number is less than or equal to `commit_seq` (unsigned). Retirement stops at the first younger load.
- R6: In each cycle with `squash_valid`, the newest load is removed if its sequence number is strictly greater than `squash_seq`. A load that is not younger stays. Allocation and commit are ignored in a squash cycle.
- R7: A check accepted from `chk_start` examines slots `chk_start`, `chk_start+1`, … (modulo DEPTH+1), one per clock, up to but excluding the tail. Without a match it ends with `chk_done`=1 and `chk_fault`=0. If the start equals the tail, it ends on the first walk cycle.
- R8: A load matches when it has executed and its address shifted right by LINE_SHIFT (default 8) equals the store address shifted the same way.
- R9: A slot whose current load has not executed never matches, even if the slot holds a stale address from a previous load.
- R10: On the first match in walk order, `chk_done` and `chk_fault` pulse together. `viol_valid` is set with that load's slot, sequence number and store tag.
- R11: While `viol_valid` is 1, a check request does not walk. It ends on the next cycle with `chk_fault`=0 and leaves the violator unchanged. `viol_read` clears `viol_valid`.
- R12: `free_count` always equals the physical size minus occupancy minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_valid | input | 1 | Allocate a load this cycle |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| sq_empty | input | 1 | Store queue holds no stores |
| sq_tail | input | SQ_IDX_W | Current store-queue tail |
| alloc_idx | output | IW | Slot the next allocation will use |
| full | output | 1 | Queue holds DEPTH loads |
| free_count | output | IW | Free slots |
| exec_valid | input | 1 | Write an executed address |
| exec_idx | input | IW | Slot of the executed load |
| exec_addr | input | ADDR_W | Effective address |
| commit_valid | input | 1 | Retire step request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash step request |
| squash_seq | input | SEQ_W | Loads younger than this are removed |
| chk_valid | input | 1 | Store check request |
| chk_start | input | IW | Load slot captured by the store |
| chk_addr | input | ADDR_W | Store effective address |
| chk_busy | output | 1 | Walk in progress |
| chk_done | output | 1 | Check finished (one cycle) |
| chk_fault | output | 1 | Check found an ordering violation |
| viol_valid | output | 1 | A violator is held |
| viol_idx | output | IW | Slot of the violating load |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| viol_sqtag | output | SQ_IDX_W+1 | Store tag of the violating load |
| viol_read | input | 1 | Consume the violator |

## Verification
The bench aims at a walk that wraps from the last physical slot to slot 0. A design with wrong modulo arithmetic there would miss the match or run past the tail. It puts two matching loads in one walk, so a design that keeps the last match instead of the first reports the wrong slot. It reuses a slot that still holds a matching stale address, which catches a design that keeps the executed flag across reallocation. It also checks the case where a request arrives while a violator is pending. A design that rescans in that case would replace the held violator.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_WALK = 1'b1
  } lq_scan_e;
endpackage

// File: rtl/lq_entries.sv
module lq_entries #(
  parameter int PSIZE  = 5,
  parameter int IW     = 3,
  parameter int SEQ_W  = 8,
  parameter int ADDR_W = 16,
  parameter int TW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [IW-1:0]     wr_idx,
  input  logic [SEQ_W-1:0]  wr_seq,
  input  logic [TW-1:0]     wr_tag,
  input  logic              exec_we,
  input  logic [IW-1:0]     exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [IW-1:0]     rd_head_idx,
  output logic [SEQ_W-1:0]  rd_head_seq,
  input  logic [IW-1:0]     rd_last_idx,
  output logic [SEQ_W-1:0]  rd_last_seq,
  input  logic [IW-1:0]     rd_scan_idx,
  output logic [SEQ_W-1:0]  rd_scan_seq,
  output logic [ADDR_W-1:0] rd_scan_addr,
  output logic              rd_scan_exec,
  output logic [TW-1:0]     rd_scan_tag
);
  logic [SEQ_W-1:0]  seq_a  [PSIZE];
  logic [ADDR_W-1:0] addr_a [PSIZE];
  logic [TW-1:0]     tag_a  [PSIZE];
  logic              exe_a  [PSIZE];

  for (genvar i = 0; i < PSIZE; i++) begin : g_slot
    logic              hit_alloc, hit_exec;
    logic [SEQ_W-1:0]  seq_r;
    logic [ADDR_W-1:0] addr_r;
    logic [TW-1:0]     tag_r;
    logic              exe_r;

    assign hit_alloc = alloc_we && (wr_idx == IW'(i));
    assign hit_exec  = exec_we && (exec_idx == IW'(i)) && !hit_alloc;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         exe_r <= 1'b0;
      else if (hit_alloc) exe_r <= 1'b0;
      else if (hit_exec)  exe_r <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) begin
        seq_r <= wr_seq;
        tag_r <= wr_tag;
      end
      if (hit_exec) addr_r <= exec_addr;
    end

    assign seq_a[i]  = seq_r;
    assign addr_a[i] = addr_r;
    assign tag_a[i]  = tag_r;
    assign exe_a[i]  = exe_r;
  end

  assign rd_head_seq  = seq_a[rd_head_idx];
  assign rd_last_seq  = seq_a[rd_last_idx];
  assign rd_scan_seq  = seq_a[rd_scan_idx];
  assign rd_scan_addr = addr_a[rd_scan_idx];
  assign rd_scan_exec = exe_a[rd_scan_idx];
  assign rd_scan_tag  = tag_a[rd_scan_idx];
endmodule

// File: rtl/lq_scan.sv
module lq_scan
  import lq_pkg::*;
#(
  parameter int PSIZE      = 5,
  parameter int IW         = 3,
  parameter int SEQ_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int TW         = 4,
  parameter int LINE_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     tail,
  input  logic              chk_valid,
  input  logic [IW-1:0]     chk_start,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [IW-1:0]     scan_idx,
  input  logic [SEQ_W-1:0]  ent_seq,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic              ent_exec,
  input  logic [TW-1:0]     ent_tag,
  input  logic              viol_read,
  output logic              chk_busy,
  output logic              chk_done,
  output logic              chk_fault,
  output logic              viol_valid,
  output logic [IW-1:0]     viol_idx,
  output logic [SEQ_W-1:0]  viol_seq,
  output logic [TW-1:0]     viol_sqtag
);
  lq_scan_e          st_q, st_nx;
  logic [IW-1:0]     ptr_q, ptr_nx;
  logic [ADDR_W-1:0] key_q, key_nx;
  logic              done_q, done_nx, flt_q, flt_nx;
  logic              vv_q, vv_nx;
  logic [IW-1:0]     vidx_q, vidx_nx;
  logic [SEQ_W-1:0]  vseq_q, vseq_nx;
  logic [TW-1:0]     vtag_q, vtag_nx;

  function automatic logic [IW-1:0] ring_inc(input logic [IW-1:0] x);
    return (x == IW'(PSIZE-1)) ? '0 : x + 1'b1;
  endfunction

  always_comb begin
    st_nx   = st_q;
    ptr_nx  = ptr_q;
    key_nx  = key_q;
    done_nx = 1'b0;
    flt_nx  = 1'b0;
    vv_nx   = vv_q;
    vidx_nx = vidx_q;
    vseq_nx = vseq_q;
    vtag_nx = vtag_q;
    if (viol_read && vv_q) vv_nx = 1'b0;
    case (st_q)
      SC_IDLE: begin
        if (chk_valid) begin
          if (vv_q) begin
            done_nx = 1'b1;
          end else begin
            st_nx  = SC_WALK;
            ptr_nx = chk_start;
            key_nx = chk_addr >> LINE_SHIFT;
          end
        end
      end
      SC_WALK: begin
        if (ptr_q == tail) begin
          st_nx   = SC_IDLE;
          done_nx = 1'b1;
        end else if (ent_exec && ((ent_addr >> LINE_SHIFT) == key_q)) begin
          st_nx   = SC_IDLE;
          done_nx = 1'b1;
          flt_nx  = 1'b1;
          vv_nx   = 1'b1;
          vidx_nx = ptr_q;
          vseq_nx = ent_seq;
          vtag_nx = ent_tag;
        end else begin
          ptr_nx = ring_inc(ptr_q);
        end
      end
      default: st_nx = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SC_IDLE;
      ptr_q  <= '0;
      key_q  <= '0;
      done_q <= 1'b0;
      flt_q  <= 1'b0;
      vv_q   <= 1'b0;
      vidx_q <= '0;
      vseq_q <= '0;
      vtag_q <= '0;
    end else begin
      st_q   <= st_nx;
      ptr_q  <= ptr_nx;
      key_q  <= key_nx;
      done_q <= done_nx;
      flt_q  <= flt_nx;
      vv_q   <= vv_nx;
      vidx_q <= vidx_nx;
      vseq_q <= vseq_nx;
      vtag_q <= vtag_nx;
    end
  end

  assign scan_idx   = ptr_q;
  assign chk_busy   = (st_q == SC_WALK);
  assign chk_done   = done_q;
  assign chk_fault  = flt_q;
  assign viol_valid = vv_q;
  assign viol_idx   = vidx_q;
  assign viol_seq   = vseq_q;
  assign viol_sqtag = vtag_q;

  // R10: a fault always comes with done and a held violator
  p_fault_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |-> (chk_done && viol_valid));
  // R11: violator stays until read
  p_viol_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !viol_read) |=> (viol_valid && $stable(viol_idx) && $stable(viol_seq)));
  // R7: the walk is over when done is reported
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> !chk_busy);
endmodule

// File: rtl/lq_order_queue.sv
module lq_order_queue #(
  parameter int DEPTH      = 4,
  parameter int SEQ_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int SQ_IDX_W   = 3,
  parameter int LINE_SHIFT = 8,
  localparam int PSIZE     = DEPTH + 1,
  localparam int IW        = $clog2(PSIZE),
  localparam int TW        = SQ_IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic              sq_empty,
  input  logic [SQ_IDX_W-1:0] sq_tail,
  output logic [IW-1:0]     alloc_idx,
  output logic              full,
  output logic [IW-1:0]     free_count,
  input  logic              exec_valid,
  input  logic [IW-1:0]     exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              chk_valid,
  input  logic [IW-1:0]     chk_start,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_busy,
  output logic              chk_done,
  output logic              chk_fault,
  output logic              viol_valid,
  output logic [IW-1:0]     viol_idx,
  output logic [SEQ_W-1:0]  viol_seq,
  output logic [TW-1:0]     viol_sqtag,
  input  logic              viol_read
);
  logic [1:0]        rsync_q;
  logic              rst_s;
  logic [IW-1:0]     head_q, head_nx, tail_q, tail_nx, last_idx, scan_idx;
  logic [IW:0]       occ;
  logic              empty, al_do, cm_do, sq_do;
  logic [SEQ_W-1:0]  head_seq, last_seq, scan_seq;
  logic [ADDR_W-1:0] scan_addr;
  logic              scan_exec;
  logic [TW-1:0]     scan_tag, new_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  function automatic logic [IW-1:0] ring_inc(input logic [IW-1:0] x);
    return (x == IW'(PSIZE-1)) ? '0 : x + 1'b1;
  endfunction
  function automatic logic [IW-1:0] ring_dec(input logic [IW-1:0] x);
    return (x == '0) ? IW'(PSIZE-1) : x - 1'b1;
  endfunction

  always_comb begin
    if (tail_q >= head_q) occ = {1'b0, tail_q} - {1'b0, head_q};
    else                  occ = {1'b0, tail_q} + (IW+1)'(PSIZE) - {1'b0, head_q};
  end
  assign empty      = (occ == '0);
  assign full       = (occ == (IW+1)'(DEPTH));
  assign free_count = IW'((IW+1)'(DEPTH) - occ);
  assign last_idx   = ring_dec(tail_q);
  assign new_tag    = sq_empty ? {1'b1, {SQ_IDX_W{1'b0}}} : {1'b0, sq_tail};

  assign sq_do = squash_valid && !empty && (last_seq > squash_seq);
  assign cm_do = commit_valid && !squash_valid && !empty && (head_seq <= commit_seq);
  assign al_do = alloc_valid && !squash_valid && !full;

  always_comb begin
    tail_nx = tail_q;
    head_nx = head_q;
    if (sq_do)      tail_nx = last_idx;
    else if (al_do) tail_nx = ring_inc(tail_q);
    if (cm_do)      head_nx = ring_inc(head_q);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_nx;
      tail_q <= tail_nx;
    end
  end
  assign alloc_idx = tail_q;

  lq_entries #(.PSIZE(PSIZE), .IW(IW), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .TW(TW)) u_entries (
    .clk(clk), .rst_n(rst_s),
    .alloc_we(al_do), .wr_idx(tail_q), .wr_seq(alloc_seq), .wr_tag(new_tag),
    .exec_we(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .rd_head_idx(head_q), .rd_head_seq(head_seq),
    .rd_last_idx(last_idx), .rd_last_seq(last_seq),
    .rd_scan_idx(scan_idx), .rd_scan_seq(scan_seq), .rd_scan_addr(scan_addr),
    .rd_scan_exec(scan_exec), .rd_scan_tag(scan_tag)
  );

  lq_scan #(.PSIZE(PSIZE), .IW(IW), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .TW(TW),
            .LINE_SHIFT(LINE_SHIFT)) u_scan (
    .clk(clk), .rst_n(rst_s), .tail(tail_q),
    .chk_valid(chk_valid), .chk_start(chk_start), .chk_addr(chk_addr),
    .scan_idx(scan_idx), .ent_seq(scan_seq), .ent_addr(scan_addr),
    .ent_exec(scan_exec), .ent_tag(scan_tag), .viol_read(viol_read),
    .chk_busy(chk_busy), .chk_done(chk_done), .chk_fault(chk_fault),
    .viol_valid(viol_valid), .viol_idx(viol_idx), .viol_seq(viol_seq),
    .viol_sqtag(viol_sqtag)
  );

  // R3: a full queue ignores allocation
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (alloc_valid && full && !squash_valid) |=> $stable(alloc_idx));
  // R5: a qualifying commit frees exactly one slot
  p_commit_frees_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (commit_valid && !squash_valid && !alloc_valid && !empty && head_seq <= commit_seq)
    |=> (free_count == $past(free_count) + 1'b1));
  // R6: a qualifying squash frees exactly one slot
  p_squash_frees_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (squash_valid && !empty && last_seq > squash_seq)
    |=> (free_count == $past(free_count) + 1'b1));
  // R12: free count never exceeds the configured depth
  p_free_bound_r12: assert property (@(posedge clk) disable iff (!rst_s)
    free_count <= IW'(DEPTH));
endmodule

// File: tb/test_lq_order_queue.sv
module test_lq_order_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, SEQ_W = 8, ADDR_W = 16, SQ_IDX_W = 3, IW = 3, TW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, sq_empty, exec_valid, commit_valid, squash_valid, chk_valid, viol_read;
  logic [SEQ_W-1:0] alloc_seq, commit_seq, squash_seq;
  logic [SQ_IDX_W-1:0] sq_tail;
  logic [IW-1:0] alloc_idx, free_count, exec_idx, chk_start, viol_idx;
  logic [ADDR_W-1:0] exec_addr, chk_addr;
  logic full, chk_busy, chk_done, chk_fault, viol_valid;
  logic [SEQ_W-1:0] viol_seq;
  logic [TW-1:0] viol_sqtag;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic fault;
    logic [IW-1:0] idx;
    logic [SEQ_W-1:0] seq;
    logic [TW-1:0] tag;
    string req;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lq_order_queue i_lq_order_queue (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .sq_empty(sq_empty), .sq_tail(sq_tail), .alloc_idx(alloc_idx), .full(full),
    .free_count(free_count), .exec_valid(exec_valid), .exec_idx(exec_idx),
    .exec_addr(exec_addr), .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .chk_valid(chk_valid),
    .chk_start(chk_start), .chk_addr(chk_addr), .chk_busy(chk_busy),
    .chk_done(chk_done), .chk_fault(chk_fault), .viol_valid(viol_valid),
    .viol_idx(viol_idx), .viol_seq(viol_seq), .viol_sqtag(viol_sqtag),
    .viol_read(viol_read)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && chk_done) begin
      if (sb.size() == 0) begin
        check("R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " fault"}, chk_fault, e.fault);
        if (e.fault) begin
          check({e.req, " viol_idx"}, viol_idx, e.idx);
          check({e.req, " viol_seq"}, viol_seq, e.seq);
          check({e.req, " viol_sqtag"}, viol_sqtag, e.tag);
        end
      end
    end
  end

  task automatic do_alloc(input int seq, input bit sqe, input int sqt);
    alloc_valid = 1'b1; alloc_seq = SEQ_W'(seq); sq_empty = sqe; sq_tail = SQ_IDX_W'(sqt);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_exec(input int idx, input int addr);
    exec_valid = 1'b1; exec_idx = IW'(idx); exec_addr = ADDR_W'(addr);
    @(negedge clk);
    exec_valid = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic do_check(input int start, input int addr, input bit f, input int idx,
                          input int seq, input int tag, input string req);
    exp_t e;
    e.fault = f; e.idx = IW'(idx); e.seq = SEQ_W'(seq); e.tag = TW'(tag); e.req = req;
    sb.push_back(e);
    chk_valid = 1'b1; chk_start = IW'(start); chk_addr = ADDR_W'(addr);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk_valid = 1'b0;
      if (chk_done) break;
    end
    @(negedge clk);
  endtask

  task automatic do_read();
    viol_read = 1'b1;
    @(negedge clk);
    viol_read = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 0; sq_empty = 0; exec_valid = 0; commit_valid = 0; squash_valid = 0;
    chk_valid = 0; viol_read = 0; alloc_seq = 0; commit_seq = 0; squash_seq = 0;
    sq_tail = 0; exec_idx = 0; exec_addr = 0; chk_start = 0; chk_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 free_count", free_count, DEPTH);
    check("R1 full", full, 0);
    check("R1 viol_valid", viol_valid, 0);
    check("R1 chk_busy", chk_busy, 0);
    check("R1 alloc_idx", alloc_idx, 0);

    // R2 / R4 allocation
    do_alloc(10, 1, 0); check("R2 free after 1", free_count, 3); check("R2 idx", alloc_idx, 1);
    do_alloc(20, 0, 1); check("R2 free after 2", free_count, 2);
    do_alloc(30, 0, 2);
    do_alloc(40, 0, 3); check("R12 free at full", free_count, 0);
    check("R3 full", full, 1);
    do_alloc(99, 0, 5);
    check("R3 idx unchanged", alloc_idx, 4); check("R3 free unchanged", free_count, 0);

    do_exec(0, 'h1234);
    do_exec(1, 'h5600);
    do_exec(3, 'h12FF);

    // R8 coarse match; slot 2 unexecuted (R9)
    do_check(1, 'h12AB, 1, 3, 40, 3, "R8 coarse match");
    // R11 pending violator blocks a new scan
    do_check(0, 'h1200, 0, 0, 0, 0, "R11 pending");
    check("R11 viol kept", viol_idx, 3);
    check("R11 viol valid", viol_valid, 1);
    do_read();
    check("R11 read clears", viol_valid, 0);
    // R10 first match wins, R4 no-store marker
    do_check(0, 'h1200, 1, 0, 10, 8, "R10 first match R4 tag");
    do_read();
    // R7 no match; R8 neighbouring region
    do_check(1, 'h7700, 0, 0, 0, 0, "R7 no match");
    do_check(3, 'h1300, 0, 0, 0, 0, "R8 other region");

    // R5 commit up to seq 25
    commit_valid = 1'b1; commit_seq = 25;
    @(negedge clk); check("R5 retire 1", free_count, 1);
    @(negedge clk); check("R5 retire 2", free_count, 2);
    @(negedge clk); check("R5 stops at younger", free_count, 2);
    commit_valid = 1'b0;

    // R2 wrap
    do_alloc(50, 0, 4); check("R2 wrap to 0", alloc_idx, 0);
    do_alloc(60, 0, 5); check("R2 after wrap", alloc_idx, 1);
    // R9 stale address in reused slot 0 must not match
    do_check(4, 'h1200, 0, 0, 0, 0, "R9 stale slot");

    // R6 squash above 45, alloc ignored in squash cycle
    squash_valid = 1'b1; squash_seq = 45; alloc_valid = 1'b1; alloc_seq = 77;
    @(negedge clk); alloc_valid = 1'b0; check("R6 squash 1", free_count, 1);
    @(negedge clk); check("R6 squash 2", free_count, 2);
    @(negedge clk); check("R6 stop at older", free_count, 2);
    squash_valid = 1'b0;
    check("R6 tail pulled back", alloc_idx, 4);

    // R7 start equals tail
    do_check(4, 'h1200, 0, 0, 0, 0, "R7 empty range");

    // R7 / R10 walk across wrap
    do_alloc(70, 0, 6);
    do_alloc(80, 0, 7);
    do_exec(0, 'hAB00);
    do_check(3, 'hAB55, 1, 0, 80, 7, "R7 wrap walk");
    do_read();
    check("R11 cleared", viol_valid, 0);
    check("R7 all checks consumed", sb.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule